// File: doc/BRIEF.md
# Splittable Signed Multiplier Cell

A pipelined multiplier cell with one static setting that picks its shape. It either forms a single 18x18 product across the whole 36-bit result, or it acts as two separate 9x9 multipliers. In the second shape, the low and high halves of each operand drive separate lanes. Each operand comes with a dynamic sign-control input, `sgn_a` or `sgn_b`, which chooses whether that operand is read as two's complement or as unsigned.

Every storage point is chosen at elaboration time, and each can be registered or made transparent on its own:
- the four 9-bit operand segments,
- the two sign controls,
- the two 18-bit product segments.

Each sign control can also be inverted at the point where it is used. A shared clock enable and a synchronous clear act on every register that is present. An active-low asynchronous reset initialises the registers.

Top module: `split_mul_cell`

## Requirements
- R1: With `MODE = MODE_FULL`, `prod[35:0]` is the product of `opa` and `opb`. The result is reduced modulo 2^36, so it is exact for every operand pair.
- R2: With `MODE = MODE_SPLIT`, `prod[17:0]` is the 18-bit product of `opa[8:0]` and `opb[8:0]`. `prod[35:18]` is the 18-bit product of `opa[17:9]` and `opb[17:9]`. Neither lane's inputs affect the other lane.
- R3: An effective sign flag of 1 makes the matching operand two's complement. In split mode this applies to each 9-bit sub-operand, with bit 8 or bit 17 as the sign bit. A flag of 0 makes the operand unsigned.
- R4: Bit 0 of `SGN_INV` inverts the `sgn_a` path and bit 1 inverts the `sgn_b` path. The inversion is applied after the sign register, at the point of use.
- R5: Bit s of `IN_REG_A` and of `IN_REG_B` places a register on operand segment s, where s=0 is bits 8:0 and s=1 is bits 17:9. When the bit is 0, that segment passes straight through.
- R6: Bit s of `OUT_REG` places a register on `prod[18*s+17:18*s]`. When the bit is 0, that product segment is combinational.
- R7: Bit 0 of `SGN_REG` registers the `sgn_a` path and bit 1 registers the `sgn_b` path. These registers are set independently of the data registers.
- R8: Each product segment lags its inputs by a number of cycles equal to the registers on the path, which is 0, 1 or 2. Every input segment and sign path is counted on its own.
- R9: While `ce` is low and `srst` is low, every present register holds its value.
- R10: `srst` high at a rising edge clears every present register to zero, whatever `ce` is.
- R11: `rst_n` low clears every present register to zero at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| srst | input | 1 | Synchronous clear of all present registers |
| ce | input | 1 | Clock enable for all present registers |
| opa | input | 18 | Operand A |
| opb | input | 18 | Operand B |
| sgn_a | input | 1 | Sign control for operand A, before optional inversion |
| sgn_b | input | 1 | Sign control for operand B, before optional inversion |
| prod | output | 36 | Product word, or two 18-bit lane products in split mode |

## Verification
Each output segment is due 0, 1 or 2 enabled edges after its inputs. The count is that segment's output register plus the register, if any, on the particular input segment or sign path being traced. Different contributing inputs can therefore arrive with different lags.

The reference model records the operands and sign controls that were captured at every enabled edge. It rebuilds each segment's operands from the entries at the depth that path implies, and zeroes every entry on either reset. Four instances with different register, inversion and mode settings are compared on every falling edge. At that point the inputs of the cycle are stable and the registers have settled, so a transparent path and a two-stage path are both checked in the cycle their result is due.

// File: rtl/split_mul_pkg.sv
package split_mul_pkg;

  typedef enum logic {
    MODE_FULL  = 1'b0,
    MODE_SPLIT = 1'b1
  } mul_mode_e;

  localparam int unsigned NUM_SEG = 2;

endpackage

// File: rtl/pipe_seg.sv
module pipe_seg #(
  parameter int unsigned W  = 9,
  parameter bit          EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         srst,
  input  logic         ce,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  if (EN) begin : g_reg
    logic [W-1:0] q_r;
    logic [W-1:0] q_nxt;

    always_comb begin
      if (srst)    q_nxt = '0;
      else if (ce) q_nxt = d;
      else         q_nxt = q_r;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_r <= '0;
      else        q_r <= q_nxt;
    end

    assign q = q_r;

    // R5 R6 R7: an enabled edge captures the input one cycle later
    p_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && !srst) |=> (q == $past(d)));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce && !srst) |=> $stable(q));

    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> (q == '0));
  end else begin : g_bypass
    logic byp_unused;
    assign byp_unused = ^{clk, rst_n, srst, ce};
    assign q = d;
  end

endmodule

// File: rtl/split_mul_core.sv
module split_mul_core
  import split_mul_pkg::*;
#(
  parameter int unsigned SEG_W = 9,
  parameter mul_mode_e   MODE  = MODE_FULL
) (
  input  logic [2*SEG_W-1:0] a,
  input  logic [2*SEG_W-1:0] b,
  input  logic               sa,
  input  logic               sb,
  output logic [4*SEG_W-1:0] p
);

  localparam int unsigned OP_W = 2 * SEG_W;
  localparam int unsigned P_W  = 2 * OP_W;

  if (MODE == MODE_FULL) begin : g_full
    logic [P_W-1:0] ax;
    logic [P_W-1:0] bx;
    assign ax = {{OP_W{sa & a[OP_W-1]}}, a};
    assign bx = {{OP_W{sb & b[OP_W-1]}}, b};
    assign p  = ax * bx;
  end else begin : g_split
    for (genvar l = 0; l < NUM_SEG; l++) begin : g_lane
      logic [SEG_W-1:0] la;
      logic [SEG_W-1:0] lb;
      logic [OP_W-1:0]  lax;
      logic [OP_W-1:0]  lbx;
      assign la  = a[l*SEG_W +: SEG_W];
      assign lb  = b[l*SEG_W +: SEG_W];
      assign lax = {{SEG_W{sa & la[SEG_W-1]}}, la};
      assign lbx = {{SEG_W{sb & lb[SEG_W-1]}}, lb};
      assign p[l*OP_W +: OP_W] = lax * lbx;
    end
  end

endmodule

// File: rtl/split_mul_cell.sv
module split_mul_cell
  import split_mul_pkg::*;
#(
  parameter int unsigned SEG_W    = 9,
  parameter mul_mode_e   MODE     = MODE_FULL,
  parameter bit [1:0]    IN_REG_A = 2'b11,
  parameter bit [1:0]    IN_REG_B = 2'b11,
  parameter bit [1:0]    SGN_REG  = 2'b11,
  parameter bit [1:0]    SGN_INV  = 2'b00,
  parameter bit [1:0]    OUT_REG  = 2'b11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 srst,
  input  logic                 ce,
  input  logic [2*SEG_W-1:0]   opa,
  input  logic [2*SEG_W-1:0]   opb,
  input  logic                 sgn_a,
  input  logic                 sgn_b,
  output logic [4*SEG_W-1:0]   prod
);

  localparam int unsigned OP_W = 2 * SEG_W;
  localparam int unsigned P_W  = 2 * OP_W;

  logic [OP_W-1:0] a_use;
  logic [OP_W-1:0] b_use;
  logic [1:0]      sgn_raw;
  logic [1:0]      sgn_q;
  logic [1:0]      sgn_eff;
  logic [P_W-1:0]  raw;

  // operand segment registers
  for (genvar s = 0; s < NUM_SEG; s++) begin : g_in
    pipe_seg #(.W(SEG_W), .EN(IN_REG_A[s])) i_seg_a (
      .clk(clk), .rst_n(rst_n), .srst(srst), .ce(ce),
      .d(opa[s*SEG_W +: SEG_W]), .q(a_use[s*SEG_W +: SEG_W]));
    pipe_seg #(.W(SEG_W), .EN(IN_REG_B[s])) i_seg_b (
      .clk(clk), .rst_n(rst_n), .srst(srst), .ce(ce),
      .d(opb[s*SEG_W +: SEG_W]), .q(b_use[s*SEG_W +: SEG_W]));
  end

  // sign control registers, inversion after the register
  assign sgn_raw = {sgn_b, sgn_a};
  for (genvar k = 0; k < 2; k++) begin : g_sgn
    pipe_seg #(.W(1), .EN(SGN_REG[k])) i_sgn (
      .clk(clk), .rst_n(rst_n), .srst(srst), .ce(ce),
      .d(sgn_raw[k]), .q(sgn_q[k]));
    assign sgn_eff[k] = sgn_q[k] ^ SGN_INV[k];
  end

  split_mul_core #(.SEG_W(SEG_W), .MODE(MODE)) i_core (
    .a(a_use), .b(b_use), .sa(sgn_eff[0]), .sb(sgn_eff[1]), .p(raw));

  // product segment registers
  for (genvar s = 0; s < NUM_SEG; s++) begin : g_out
    pipe_seg #(.W(OP_W), .EN(OUT_REG[s])) i_seg_p (
      .clk(clk), .rst_n(rst_n), .srst(srst), .ce(ce),
      .d(raw[s*OP_W +: OP_W]), .q(prod[s*OP_W +: OP_W]));
  end

  if (MODE == MODE_FULL) begin : g_chk_full
    p_zero_a_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (a_use == '0) |-> (raw == '0));

    p_unit_unsigned_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!sgn_eff[0] && !sgn_eff[1] && a_use == OP_W'(1)) |->
      (raw == {{OP_W{1'b0}}, b_use}));
  end else begin : g_chk_split
    p_lane_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (a_use[SEG_W-1:0] == '0) |-> (raw[OP_W-1:0] == '0));

    p_lane_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (b_use[OP_W-1:SEG_W] == '0) |-> (raw[P_W-1:OP_W] == '0));
  end

endmodule

// File: tb/test_split_mul_cell.sv
`timescale 1ns/1ps
module test_split_mul_cell;
  import split_mul_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        srst = 1'b0;
  logic        ce = 1'b1;
  logic [17:0] opa = '0;
  logic [17:0] opb = '0;
  logic        sgn_a = 1'b0;
  logic        sgn_b = 1'b0;
  logic [35:0] prod [0:3];

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  // per-instance configuration: split, in_a, in_b, sgn_reg, sgn_inv, out_reg
  localparam bit       C_SPL [0:3] = '{1'b0, 1'b1, 1'b0, 1'b0};
  localparam bit [1:0] C_IA  [0:3] = '{2'b11, 2'b01, 2'b00, 2'b10};
  localparam bit [1:0] C_IB  [0:3] = '{2'b11, 2'b10, 2'b00, 2'b00};
  localparam bit [1:0] C_SR  [0:3] = '{2'b11, 2'b01, 2'b00, 2'b10};
  localparam bit [1:0] C_INV [0:3] = '{2'b00, 2'b10, 2'b11, 2'b01};
  localparam bit [1:0] C_OR  [0:3] = '{2'b11, 2'b10, 2'b00, 2'b01};

  split_mul_cell #(.MODE(MODE_FULL), .IN_REG_A(C_IA[0]), .IN_REG_B(C_IB[0]),
    .SGN_REG(C_SR[0]), .SGN_INV(C_INV[0]), .OUT_REG(C_OR[0])) i_split_mul_cell (
    .clk(clk), .rst_n(rst_n), .srst(srst), .ce(ce), .opa(opa), .opb(opb),
    .sgn_a(sgn_a), .sgn_b(sgn_b), .prod(prod[0]));

  split_mul_cell #(.MODE(MODE_SPLIT), .IN_REG_A(C_IA[1]), .IN_REG_B(C_IB[1]),
    .SGN_REG(C_SR[1]), .SGN_INV(C_INV[1]), .OUT_REG(C_OR[1])) i_split_mul_cell_1 (
    .clk(clk), .rst_n(rst_n), .srst(srst), .ce(ce), .opa(opa), .opb(opb),
    .sgn_a(sgn_a), .sgn_b(sgn_b), .prod(prod[1]));

  split_mul_cell #(.MODE(MODE_FULL), .IN_REG_A(C_IA[2]), .IN_REG_B(C_IB[2]),
    .SGN_REG(C_SR[2]), .SGN_INV(C_INV[2]), .OUT_REG(C_OR[2])) i_split_mul_cell_2 (
    .clk(clk), .rst_n(rst_n), .srst(srst), .ce(ce), .opa(opa), .opb(opb),
    .sgn_a(sgn_a), .sgn_b(sgn_b), .prod(prod[2]));

  split_mul_cell #(.MODE(MODE_FULL), .IN_REG_A(C_IA[3]), .IN_REG_B(C_IB[3]),
    .SGN_REG(C_SR[3]), .SGN_INV(C_INV[3]), .OUT_REG(C_OR[3])) i_split_mul_cell_3 (
    .clk(clk), .rst_n(rst_n), .srst(srst), .ce(ce), .opa(opa), .opb(opb),
    .sgn_a(sgn_a), .sgn_b(sgn_b), .prod(prod[3]));

  // history of values captured at enabled edges; index k = k edges back
  logic [17:0] cap_a  [1:2];
  logic [17:0] cap_b  [1:2];
  logic        cap_sa [1:2];
  logic        cap_sb [1:2];

  task automatic clear_hist();
    for (int k = 1; k <= 2; k++) begin
      cap_a[k] = '0; cap_b[k] = '0; cap_sa[k] = 1'b0; cap_sb[k] = 1'b0;
    end
  endtask

  initial clear_hist();

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || srst) clear_hist();
    else if (ce) begin
      cap_a[2] = cap_a[1];   cap_a[1] = opa;
      cap_b[2] = cap_b[1];   cap_b[1] = opb;
      cap_sa[2] = cap_sa[1]; cap_sa[1] = sgn_a;
      cap_sb[2] = cap_sb[1]; cap_sb[1] = sgn_b;
    end
  end

  function automatic logic [17:0] pick_a(int d);
    if (d == 0) return opa;
    return cap_a[d];
  endfunction
  function automatic logic [17:0] pick_b(int d);
    if (d == 0) return opb;
    return cap_b[d];
  endfunction
  function automatic logic pick_sa(int d);
    if (d == 0) return sgn_a;
    return cap_sa[d];
  endfunction
  function automatic logic pick_sb(int d);
    if (d == 0) return sgn_b;
    return cap_sb[d];
  endfunction

  function automatic logic [35:0] mul_ref(logic [17:0] a, logic [17:0] b,
                                          logic sa, logic sb, bit split);
    longint x, y, p;
    logic [35:0] r;
    r = '0;
    if (!split) begin
      x = longint'(a); y = longint'(b);
      if (sa && a[17]) x = x - (64'sd1 <<< 18);
      if (sb && b[17]) y = y - (64'sd1 <<< 18);
      p = x * y;
      r = p[35:0];
    end else begin
      for (int l = 0; l < 2; l++) begin
        x = longint'((a >> (9*l)) & 18'h1FF);
        y = longint'((b >> (9*l)) & 18'h1FF);
        if (sa && x[8]) x = x - 512;
        if (sb && y[8]) y = y - 512;
        p = x * y;
        r[18*l +: 18] = p[17:0];
      end
    end
    return r;
  endfunction

  function automatic logic [35:0] model(int u);
    logic [35:0] res, full;
    logic [17:0] lo_a, hi_a, lo_b, hi_b, a, b;
    logic sa, sb;
    int d;
    res = '0;
    for (int s = 0; s < 2; s++) begin
      d = int'(C_OR[u][s]);
      lo_a = pick_a(d + int'(C_IA[u][0]));
      hi_a = pick_a(d + int'(C_IA[u][1]));
      lo_b = pick_b(d + int'(C_IB[u][0]));
      hi_b = pick_b(d + int'(C_IB[u][1]));
      a = {hi_a[17:9], lo_a[8:0]};
      b = {hi_b[17:9], lo_b[8:0]};
      sa = pick_sa(d + int'(C_SR[u][0])) ^ C_INV[u][0];
      sb = pick_sb(d + int'(C_SR[u][1])) ^ C_INV[u][1];
      full = mul_ref(a, b, sa, sb, C_SPL[u]);
      res[18*s +: 18] = full[18*s +: 18];
    end
    return res;
  endfunction

  task automatic check_all(string tag);
    logic [35:0] exp;
    for (int u = 0; u < 4; u++) begin
      exp = model(u);
      checks++;
      if (prod[u] !== exp) begin
        fails++;
        $display("FAIL %s inst%0d prod=%h expected=%h", tag, u, prod[u], exp);
      end
    end
  endtask

  // one cycle: compare at the falling edge, then drive the next inputs
  task automatic step(string tag, logic [17:0] a, logic [17:0] b,
                      logic xa, logic xb, logic en, logic clr);
    @(negedge clk);
    check_all(tag);
    opa = a; opb = b; sgn_a = xa; sgn_b = xb; ce = en; srst = clr;
  endtask

  task automatic rand_run(string tag, int n, int ce_pct, int srst_pct);
    for (int i = 0; i < n; i++)
      step(tag, 18'($urandom), 18'($urandom), 1'($urandom), 1'($urandom),
           ($urandom % 100) < ce_pct, ($urandom % 100) < srst_pct);
  endtask

  initial begin
    // R11: reset state of every instance
    for (int i = 0; i < 3; i++) step("R11", 18'h3FFFF, 18'h2AAAA, 1'b1, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    check_all("R11");
    rst_n = 1'b1;

    // R1: directed full-width corners, each held long enough to drain
    for (int i = 0; i < 3; i++) step("R1", 18'h3FFFF, 18'h3FFFF, 1'b0, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) step("R1", 18'h20000, 18'h20000, 1'b1, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) step("R1", 18'h3FFFF, 18'h1FFFF, 1'b1, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) step("R1", 18'h00000, 18'h3FFFF, 1'b1, 1'b1, 1'b1, 1'b0);
    // R2: lane corners, one lane zero while the other is extreme
    for (int i = 0; i < 3; i++) step("R2", 18'h3FE00, 18'h001FF, 1'b1, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) step("R2", 18'h20100, 18'h20100, 1'b0, 1'b1, 1'b1, 1'b0);
    // R3, R4: all sign combinations with random data
    for (int sc = 0; sc < 4; sc++)
      for (int i = 0; i < 40; i++)
        step(sc[0] ? "R3" : "R4", 18'($urandom), 18'($urandom),
             sc[0], sc[1], 1'b1, 1'b0);
    // R5, R6, R7, R8: per-segment lags under a free-running enable
    rand_run("R5", 150, 100, 0);
    rand_run("R6", 150, 100, 0);
    rand_run("R7", 150, 100, 0);
    rand_run("R8", 150, 100, 0);
    // R9: enable dropped often
    rand_run("R9", 300, 55, 0);
    // R10: synchronous clear, including with the enable low
    rand_run("R10", 300, 60, 15);
    step("R10", 18'h12345, 18'h2F0F0, 1'b1, 1'b1, 1'b0, 1'b1);
    rand_run("R10", 4, 0, 0);
    // R11: asynchronous reset in the middle of traffic
    rand_run("R11", 20, 100, 0);
    @(negedge clk);
    check_all("R11");
    rst_n = 1'b0;
    #1;
    check_all("R11");
    rand_run("R11", 3, 100, 0);
    @(negedge clk);
    rst_n = 1'b1;
    rand_run("R11", 100, 80, 5);
    @(negedge clk);
    check_all("R1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule